// File: doc/BRIEF.md
# Audio frame sync tracker

This block sits in front of an audio decoder and follows a byte stream made of fixed-length frames, each opening with a programmable sync pattern. Once started, it hunts for the pattern. On the first hit it tells the decoder to begin. It declares the stream locked only when a second pattern arrives exactly one frame later. From then on it checks each frame boundary. A missing pattern at a boundary drops the lock and starts a new search. When three consecutive boundaries are good after such a loss, the block reports a recovery.

CRC and illegal-parameter strobes come from the decoder. Either one throws the tracker back into search and clears all of its counting. Four sticky status bits record sync hits, sync loss, recovery and stream errors. A host can mask each bit and clear it with a write-one-to-clear strobe. An active-low interrupt line reports any bit that is set and not masked. A mute request covers the time the stream is known to be bad. A stop command parks the tracker and resets the read and write pointers of the input buffer.

Top module: `sft_sync_tracker`

## Requirements
- R1: After reset all status bits are 0, `irq_n_o` is 1, `locked_o`, `dec_start_o`, `mute_o` and `buf_ptr_rst_o` are 0, and the tracker is idle.
- R2: A `start_i` pulse while idle begins a search. The 12-bit pattern is matched against the byte before the current byte, followed by the upper nibble of the current byte. On the first match `dec_start_o` pulses for one cycle, starting the cycle after that byte, and `locked_o` stays 0.
- R3: `locked_o` rises once a second match lands on the expected position, which is exactly `frame_len_i` valid bytes after the byte that completed the previous accepted match. A miss at that position before lock returns to search and sets no status bit.
- R4: While locked, a miss at the expected position clears `locked_o`, sets status bit 1 (sync error) and returns to search.
- R5: After a sync loss, status bit 2 (recovery) is set when the third consecutive accepted match occurs: the search hit plus two hits at their expected positions.
- R6: Status bit 0 (sync detect) is set on every accepted match. A pattern at any position other than the expected one is ignored while verifying or locked: no status change and no loss of lock.
- R7: A `crc_err_i` or `illegal_err_i` strobe while running sets status bit 3 (stream error), clears lock and all counts, and restarts the search. Lock then again needs two matches one frame apart.
- R8: `mute_o` is 1 when `mute_en_i` is 1 and a sync loss or stream error has occurred since the last time lock was gained. `mute_o` is never 1 while locked.
- R9: `irq_n_o` is 0 exactly when some status bit is 1 and its `irq_mask_i` bit is 0. A mask bit of 1 hides that status bit.
- R10: `stop_i` has priority over every other input. It returns the tracker to idle, drops lock and pulses `buf_ptr_rst_o` for one cycle. While idle, bytes have no effect on status or `dec_start_o`.
- R11: Status bits stay set until a 1 is written to the matching `irq_clear_i` bit. If a new event and a clear arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start searching (acts only when idle) |
| stop_i | input | 1 | Stop and return to idle |
| byte_valid_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Stream byte |
| frame_len_i | input | 16 | Frame length in bytes (at least 2) |
| sync_word_i | input | 12 | Sync pattern |
| crc_err_i | input | 1 | CRC error strobe from decoder |
| illegal_err_i | input | 1 | Illegal-parameter strobe from decoder |
| mute_en_i | input | 1 | Enable mute on error |
| irq_mask_i | input | 4 | Per-status mask, 1 hides the bit |
| irq_clear_i | input | 4 | Write-one-to-clear strobe per status bit |
| dec_start_o | output | 1 | One-cycle pulse telling the decoder to begin |
| locked_o | output | 1 | Tracker is locked |
| mute_o | output | 1 | Mute request |
| buf_ptr_rst_o | output | 1 | One-cycle pulse resetting buffer pointers |
| irq_status_o | output | 4 | Sticky status: 0 detect, 1 sync error, 2 recovery, 3 stream error |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
A wrong frame count or a stale previous byte shows up as a miss or a hit at the wrong byte. At the next frame boundary, a locked stream then loses `locked_o` and raises the sync-error bit, or fails to lock. A wrong run count after loss shows as the recovery bit appearing one frame early or late. A state that survives a stream error shows as `locked_o` coming back after one match instead of two. Because the outputs are registered, each of these differs from the reference one cycle after the byte that decides it.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_IRQ  = 4;
    localparam int IRQ_DET  = 0;
    localparam int IRQ_SERR = 1;
    localparam int IRQ_REC  = 2;
    localparam int IRQ_STRM = 3;
    localparam int RUN_W    = 2;
    localparam logic [RUN_W-1:0] RUN_RECOVER = RUN_W'(2);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_VERIFY = 2'd2,
        ST_LOCKED = 2'd3
    } trk_state_e;

    typedef struct packed {
        trk_state_e       state;
        logic [RUN_W-1:0] run;
        logic             lost;
        logic             err_act;
        logic             dec_start;
        logic             buf_rst;
    } trk_regs_t;
endpackage

// File: rtl/sft_sync_match.sv
module sft_sync_match
    import sft_pkg::*;
#(
    parameter int SYNC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [SYNC_W-1:0] sync_word_i,
    output logic              hit_o
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int SHIFT  = PAIR_W - SYNC_W;

    typedef struct packed {
        logic [BYTE_W-1:0] prev;
        logic              have;
    } match_regs_t;

    match_regs_t       m_d, m_q;
    logic [SYNC_W-1:0] window_w;

    always_comb begin
        window_w = SYNC_W'({m_q.prev, byte_i} >> SHIFT);
        hit_o    = valid_i && m_q.have && (window_w == sync_word_i);
        m_d      = m_q;
        if (clear_i) begin
            m_d.prev = '0;
            m_d.have = 1'b0;
        end else if (valid_i) begin
            m_d.prev = byte_i;
            m_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end
endmodule

// File: rtl/sft_frame_counter.sv
module sft_frame_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             restart_i,
    input  logic [LEN_W-1:0] frame_len_i,
    output logic             at_expect_o
);
    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc     = cnt_q + LEN_W'(1);
        at_expect_o = valid_i && (cnt_inc == frame_len_i);
        cnt_d       = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (valid_i) begin
            cnt_d = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sft_irq_ctrl.sv
module sft_irq_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clear_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] status_o,
    output logic         irq_n_o
);
    logic [N-1:0] stat_d, stat_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            stat_d[i] = set_i[i] | (stat_q[i] & ~clear_i[i]);
        end
        status_o = stat_q;
        irq_n_o  = ~|(stat_q & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/sft_sync_tracker.sv
module sft_sync_tracker
    import sft_pkg::*;
#(
    parameter int SYNC_W = 12,
    parameter int LEN_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               byte_valid_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic [LEN_W-1:0]   frame_len_i,
    input  logic [SYNC_W-1:0]  sync_word_i,
    input  logic               crc_err_i,
    input  logic               illegal_err_i,
    input  logic               mute_en_i,
    input  logic [NUM_IRQ-1:0] irq_mask_i,
    input  logic [NUM_IRQ-1:0] irq_clear_i,
    output logic               dec_start_o,
    output logic               locked_o,
    output logic               mute_o,
    output logic               buf_ptr_rst_o,
    output logic [NUM_IRQ-1:0] irq_status_o,
    output logic               irq_n_o
);
    trk_regs_t          r_d, r_q;
    logic               hit_w;
    logic               at_exp_w;
    logic               match_clr_w;
    logic               cnt_restart_w;
    logic [NUM_IRQ-1:0] set_w;
    logic               stream_err_w;
    logic               running_w;

    sft_sync_match #(.SYNC_W(SYNC_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (match_clr_w),
        .valid_i     (byte_valid_i),
        .byte_i      (byte_i),
        .sync_word_i (sync_word_i),
        .hit_o       (hit_w)
    );

    sft_frame_counter #(.LEN_W(LEN_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (byte_valid_i),
        .restart_i   (cnt_restart_w),
        .frame_len_i (frame_len_i),
        .at_expect_o (at_exp_w)
    );

    sft_irq_ctrl #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .clear_i  (irq_clear_i),
        .mask_i   (irq_mask_i),
        .status_o (irq_status_o),
        .irq_n_o  (irq_n_o)
    );

    always_comb begin
        running_w     = (r_q.state != ST_IDLE);
        stream_err_w  = crc_err_i | illegal_err_i;
        r_d           = r_q;
        r_d.dec_start = 1'b0;
        r_d.buf_rst   = 1'b0;
        set_w         = '0;
        match_clr_w   = 1'b0;
        cnt_restart_w = 1'b0;

        if (stop_i) begin
            r_d.state   = ST_IDLE;
            r_d.buf_rst = 1'b1;
            r_d.run     = '0;
            r_d.lost    = 1'b0;
            r_d.err_act = 1'b0;
            match_clr_w = 1'b1;
        end else if (!running_w) begin
            if (start_i) begin
                r_d.state   = ST_SEARCH;
                match_clr_w = 1'b1;
            end
        end else if (stream_err_w) begin
            set_w[IRQ_STRM] = 1'b1;
            r_d.state       = ST_SEARCH;
            r_d.run         = '0;
            r_d.lost        = 1'b0;
            r_d.err_act     = 1'b1;
            match_clr_w     = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_SEARCH: begin
                    if (hit_w) begin
                        set_w[IRQ_DET] = 1'b1;
                        r_d.dec_start  = 1'b1;
                        cnt_restart_w  = 1'b1;
                        r_d.state      = ST_VERIFY;
                        r_d.run        = RUN_W'(1);
                    end
                end
                ST_VERIFY: begin
                    if (at_exp_w) begin
                        if (hit_w) begin
                            set_w[IRQ_DET] = 1'b1;
                            cnt_restart_w  = 1'b1;
                            r_d.state      = ST_LOCKED;
                            r_d.run        = RUN_W'(2);
                            r_d.err_act    = 1'b0;
                        end else begin
                            r_d.state = ST_SEARCH;
                            r_d.run   = '0;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_exp_w) begin
                        if (hit_w) begin
                            set_w[IRQ_DET] = 1'b1;
                            cnt_restart_w  = 1'b1;
                            if (r_q.lost && (r_q.run == RUN_RECOVER)) begin
                                set_w[IRQ_REC] = 1'b1;
                                r_d.lost       = 1'b0;
                            end
                            if (r_q.run != '1) begin
                                r_d.run = r_q.run + RUN_W'(1);
                            end
                        end else begin
                            set_w[IRQ_SERR] = 1'b1;
                            r_d.state       = ST_SEARCH;
                            r_d.run         = '0;
                            r_d.lost        = 1'b1;
                            r_d.err_act     = 1'b1;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end

        dec_start_o   = r_q.dec_start;
        buf_ptr_rst_o = r_q.buf_rst;
        locked_o      = (r_q.state == ST_LOCKED);
        mute_o        = mute_en_i & r_q.err_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, run: '0, lost: 1'b0, err_act: 1'b0,
                     dec_start: 1'b0, buf_rst: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/sft_sync_tracker_chk.sv
module sft_sync_tracker_chk
    import sft_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               running_i,
    input logic               stop_i,
    input logic               crc_err_i,
    input logic               illegal_err_i,
    input logic [NUM_IRQ-1:0] irq_clear_i,
    input logic               dec_start_o,
    input logic               locked_o,
    input logic               mute_o,
    input logic               buf_ptr_rst_o,
    input logic [NUM_IRQ-1:0] irq_status_o,
    input logic               irq_n_o
);
    // R2
    start_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start_o |-> !locked_o);

    // R10
    stop_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (buf_ptr_rst_o && !locked_o));

    // R7
    stream_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_i && !stop_i && (crc_err_i || illegal_err_i))
        |=> (!locked_o && irq_status_o[IRQ_STRM]));

    // R8
    mute_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> !mute_o);

    // R5
    recover_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status_o[IRQ_REC]) |-> locked_o);

    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (irq_status_o != '0));

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_sticky
        // R11
        sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status_o[i] && !irq_clear_i[i]) |=> irq_status_o[i]);
    end
endmodule

bind sft_sync_tracker sft_sync_tracker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .running_i     (running_w),
    .stop_i        (stop_i),
    .crc_err_i     (crc_err_i),
    .illegal_err_i (illegal_err_i),
    .irq_clear_i   (irq_clear_i),
    .dec_start_o   (dec_start_o),
    .locked_o      (locked_o),
    .mute_o        (mute_o),
    .buf_ptr_rst_o (buf_ptr_rst_o),
    .irq_status_o  (irq_status_o),
    .irq_n_o       (irq_n_o)
);

// File: tb/sft_sync_tracker_tb.sv
`timescale 1ns/1ps
module sft_sync_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [15:0] frame_len_i = 16'd6;
    logic [11:0] sync_word_i = 12'hA5C;
    logic        crc_err_i = 1'b0, illegal_err_i = 1'b0;
    logic        mute_en_i = 1'b1;
    logic [3:0]  irq_mask_i = 4'h0, irq_clear_i = 4'h0;
    logic        dec_start_o, locked_o, mute_o, buf_ptr_rst_o, irq_n_o;
    logic [3:0]  irq_status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sft_sync_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .frame_len_i(frame_len_i),
        .sync_word_i(sync_word_i), .crc_err_i(crc_err_i), .illegal_err_i(illegal_err_i),
        .mute_en_i(mute_en_i), .irq_mask_i(irq_mask_i), .irq_clear_i(irq_clear_i),
        .dec_start_o(dec_start_o), .locked_o(locked_o), .mute_o(mute_o),
        .buf_ptr_rst_o(buf_ptr_rst_o), .irq_status_o(irq_status_o), .irq_n_o(irq_n_o)
    );

    // Behavioural reference: 0 idle, 1 search, 2 verify, 3 locked
    int m_state = 0, m_prev = 0, m_cnt = 0, m_run = 0;
    bit m_have = 0, m_lost = 0, m_err = 0, m_dec = 0, m_buf = 0, m_hit, m_exp, m_rs;
    logic [3:0] m_status = 4'h0, m_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_prev = 0; m_cnt = 0; m_run = 0; m_have = 0;
            m_lost = 0; m_err = 0; m_dec = 0; m_buf = 0; m_status = 4'h0;
        end else begin
            m_set = 4'h0; m_dec = 0; m_buf = 0; m_rs = 0;
            m_hit = byte_valid_i && m_have &&
                    ((((m_prev << 4) | (int'(byte_i) >> 4)) & 12'hFFF) == int'(sync_word_i));
            m_exp = byte_valid_i && (((m_cnt + 1) & 16'hFFFF) == int'(frame_len_i));
            if (stop_i) begin
                m_state = 0; m_buf = 1; m_run = 0; m_lost = 0; m_err = 0;
                m_have = 0; m_prev = 0;
            end else if (m_state == 0) begin
                if (start_i) begin m_state = 1; m_have = 0; m_prev = 0; end
                else if (byte_valid_i) begin m_prev = byte_i; m_have = 1; end
            end else if (crc_err_i || illegal_err_i) begin
                m_set[3] = 1; m_state = 1; m_run = 0; m_lost = 0; m_err = 1;
                m_have = 0; m_prev = 0;
            end else begin
                if (m_state == 1 && m_hit) begin
                    m_set[0] = 1; m_dec = 1; m_rs = 1; m_state = 2; m_run = 1;
                end else if (m_state == 2 && m_exp) begin
                    if (m_hit) begin m_set[0] = 1; m_rs = 1; m_state = 3; m_run = 2; m_err = 0; end
                    else begin m_state = 1; m_run = 0; end
                end else if (m_state == 3 && m_exp) begin
                    if (m_hit) begin
                        m_set[0] = 1; m_rs = 1;
                        if (m_lost && m_run == 2) begin m_set[2] = 1; m_lost = 0; end
                        m_run++;
                    end else begin
                        m_set[1] = 1; m_state = 1; m_run = 0; m_lost = 1; m_err = 1;
                    end
                end
                if (byte_valid_i) begin m_prev = byte_i; m_have = 1; end
            end
            if (byte_valid_i) m_cnt = m_rs ? 0 : ((m_cnt + 1) & 16'hFFFF);
            m_status = (m_status & ~irq_clear_i) | m_set;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R2 model dec_start", dec_start_o, m_dec);
            cmp("R3 model locked", locked_o, m_state == 3);
            cmp("R11 model status", irq_status_o, m_status);
            cmp("R8 model mute", mute_o, mute_en_i && m_err);
            cmp("R10 model buf_rst", buf_ptr_rst_o, m_buf);
            cmp("R9 model irq_n", irq_n_o, (m_status & ~irq_mask_i) == 0);
        end
    end

    task automatic put(input logic [7:0] b);
        byte_valid_i = 1'b1; byte_i = b;
        @(negedge clk);
        byte_valid_i = 1'b0; byte_i = 8'h00;
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) put(8'h00);
    endtask

    task automatic clear_all();
        irq_clear_i = 4'hF; @(negedge clk); irq_clear_i = 4'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 reset status", irq_status_o, 0);
        cmp("R1 reset irq_n", irq_n_o, 1);
        cmp("R1 reset locked", locked_o, 0);

        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        put(8'hA5); put(8'hC0);
        cmp("R2 dec_start pulse", dec_start_o, 1);
        cmp("R2 not yet locked", locked_o, 0);
        cmp("R6 detect bit", irq_status_o[0], 1);
        fill(4);
        put(8'hA5); put(8'hC0);
        cmp("R3 locked on second sync", locked_o, 1);
        fill(4);

        // R6: misplaced pattern while locked is ignored
        put(8'hA5); put(8'hC0);
        irq_clear_i = 4'h1; @(negedge clk); irq_clear_i = 4'h0;
        cmp("R11 detect cleared", irq_status_o[0], 0);
        put(8'hA5); put(8'hC0);
        cmp("R6 misplaced sync ignored status", irq_status_o[0], 0);
        cmp("R6 misplaced sync keeps lock", locked_o, 1);
        fill(2);

        // R4: sync missing at boundary
        put(8'hA5); put(8'h00);
        cmp("R4 lock lost", locked_o, 0);
        cmp("R4 sync error bit", irq_status_o[1], 1);
        cmp("R8 mute after loss", mute_o, 1);
        fill(4);
        put(8'hA5); put(8'hC0);
        cmp("R2 dec_start after loss", dec_start_o, 1);
        fill(4);
        put(8'hA5); put(8'hC0);
        cmp("R3 relocked", locked_o, 1);
        cmp("R8 mute released on lock", mute_o, 0);
        cmp("R5 no early recovery", irq_status_o[2], 0);
        fill(4);
        put(8'hA5); put(8'hC0);
        cmp("R5 recovery on third sync", irq_status_o[2], 1);

        irq_mask_i = 4'hF; @(negedge clk);
        cmp("R9 all masked", irq_n_o, 1);
        irq_mask_i = 4'h0; @(negedge clk);
        cmp("R9 unmasked", irq_n_o, 0);
        clear_all();
        cmp("R11 w1c all", irq_status_o, 0);
        fill(4);

        crc_err_i = 1'b1; @(negedge clk); crc_err_i = 1'b0;
        cmp("R7 stream error bit", irq_status_o[3], 1);
        cmp("R7 lock dropped", locked_o, 0);
        cmp("R8 mute on stream error", mute_o, 1);
        put(8'hA5); put(8'hC0);
        cmp("R7 single sync no lock", locked_o, 0);
        fill(4);
        put(8'hA5); put(8'hC0);
        cmp("R7 relock after two", locked_o, 1);
        illegal_err_i = 1'b1; @(negedge clk); illegal_err_i = 1'b0;
        cmp("R7 illegal param unlocks", locked_o, 0);

        clear_all();
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        cmp("R10 buf reset pulse", buf_ptr_rst_o, 1);
        cmp("R10 unlocked", locked_o, 0);
        put(8'hA5); put(8'hC0);
        cmp("R10 buf pulse single", buf_ptr_rst_o, 0);
        cmp("R10 idle no dec_start", dec_start_o, 0);
        cmp("R10 idle no status", irq_status_o, 0);

        // R3: miss while verifying is silent
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        put(8'hA5); put(8'hC0); fill(4);
        put(8'hA5); put(8'h00);
        cmp("R3 verify miss no lock", locked_o, 0);
        cmp("R3 verify miss no error", irq_status_o[1], 0);

        // R11: event beats clear in same cycle
        fill(2);
        byte_valid_i = 1'b1; byte_i = 8'hA5; @(negedge clk);
        byte_i = 8'hC0; irq_clear_i = 4'h1; @(negedge clk);
        byte_valid_i = 1'b0; irq_clear_i = 4'h0;
        cmp("R11 set wins over clear", irq_status_o[0], 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule